// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address by reading descriptors from a two-level translation table in memory. A request carries the virtual address and the table base value. The walker makes one descriptor read when the first-level entry maps a 1 MB section. It makes two reads when that entry points to a second-level table of 64 KB large pages or 4 KB small pages. It then returns the physical address, the cacheable and bufferable flags, the domain number and the 2-bit access permission code that applies to this access. An unusable descriptor produces a fault flag, along with the level at which the walk stopped.

Descriptor reads leave on a valid/ready read channel, and the data returns on a valid-only response channel. The controller is a six-state machine:
- `ST_IDLE` accepts a request (IDLE→L1_ISSUE).
- `ST_L1_ISSUE` presents the first-level address until it is accepted (→L1_WAIT).
- `ST_L1_WAIT` decodes the first-level response. A table pointer moves to L2_ISSUE. A section or a fault moves to REPLY.
- `ST_L2_ISSUE` presents the second-level address until it is accepted (→L2_WAIT).
- `ST_L2_WAIT` decodes the page descriptor (→REPLY).
- `ST_REPLY` holds the result valid for one cycle (→IDLE).

The permission check against the domain and the current mode is left to the consumer of the result. Caching of translations is also left to the consumer.

Top module: `mmu_table_walker`

## Requirements
- R1: The first read address is {table_base[31:14], vaddr[31:20], 2'b00}.
- R2: A first-level descriptor with bits 1:0 = 2'b10 is a section. The result is physical address {desc[31:20], vaddr[19:0]}, permission desc[11:10] and domain desc[8:5]. Exactly one read is made.
- R3: The cacheable output is bit 3 and the bufferable output is bit 2 of the descriptor that maps the access (the section descriptor or the second-level descriptor).
- R4: A first-level descriptor with bits 1:0 = 2'b01 points to a page table. The second read address is {desc1[31:10], vaddr[19:12], 2'b00}, and the domain is desc1[8:5].
- R5: A second-level descriptor with bits 1:0 = 2'b10 is a small page. The result is physical address {desc2[31:12], vaddr[11:0]}.
- R6: A second-level descriptor with bits 1:0 = 2'b01 is a large page. The result is physical address {desc2[31:16], vaddr[15:0]}. A large-page descriptor with any of bits 15:12 set is reported as a page fault.
- R7: A page descriptor holds four 2-bit permission codes. The subpage index k is vaddr[11:10] for small pages and vaddr[15:14] for large pages, and it selects desc2[2k+5:2k+4].
- R8: First-level types 2'b00 and 2'b11 give a fault with fault_page = 0. No second read is made, and the physical address, flags, domain and permission are all zero.
- R9: Second-level types 2'b00 and 2'b11 give a fault with fault_page = 1. The physical address, flags and permission are zero.
- R10: While a read request is not accepted, mem_rd_valid stays high and mem_rd_addr stays unchanged.
- R11: req_ready is high only in the idle state. Each accepted request yields exactly one res_valid pulse of one cycle.
- R12: After reset, req_ready = 1, mem_rd_valid = 0 and res_valid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_table_base | input | 32 | Translation table base value |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 32 | Descriptor address (word aligned) |
| mem_rsp_valid | input | 1 | Descriptor data returned |
| mem_rsp_data | input | 32 | Descriptor word |
| res_valid | output | 1 | Result valid for one cycle |
| res_paddr | output | 32 | Physical address (zero on fault) |
| res_cacheable | output | 1 | Cacheable flag |
| res_bufferable | output | 1 | Bufferable flag |
| res_domain | output | 4 | Domain number |
| res_ap | output | 2 | Access permission code for this access |
| res_fault | output | 1 | Translation fault |
| res_fault_page | output | 1 | Fault level: 0 section level, 1 page level |

## Verification
The assertions rely on the memory side returning exactly one response for each accepted read, and only while the walker waits for it. They also rely on req_valid being raised only while the walker is idle. The bench's memory model enforces both. It answers a read a fixed latency after the handshake, and it stalls the ready signal for a chosen number of cycles to exercise the hold rule. Each scenario task issues a single request, waits for the result, and only then starts the next request. Table contents are stored at the addresses the bench derives from the requirements, so any miscomputed address returns a zero descriptor and shows up as a fault.

// File: rtl/mmu_walk_pkg.sv
package mmu_walk_pkg;

    localparam int AW        = 32;   // address width
    localparam int DW        = 32;   // descriptor width
    localparam int DOM_W     = 4;    // domain field width
    localparam int AP_W      = 2;    // permission code width
    localparam int NSUB      = 4;    // subpages per page
    localparam int SUB_SEL_W = $clog2(NSUB);

    // bit boundaries used by the table format
    localparam int TB_LSB       = 14; // table base kept bits
    localparam int SECT_LSB     = 20; // section base / first-level index
    localparam int L2_BASE_LSB  = 10; // page table base
    localparam int SMALL_LSB    = 12; // small page base / second-level index
    localparam int LARGE_LSB    = 16; // large page base
    localparam int AP_LSB       = 4;  // first subpage permission field
    localparam int SECT_AP_LSB  = 10; // section permission field
    localparam int DOM_LSB      = 5;  // domain field
    localparam int SMALL_SUB_LSB = 10; // vaddr bits picking a small subpage
    localparam int LARGE_SUB_LSB = 14; // vaddr bits picking a large subpage

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_ISSUE,
        ST_L1_WAIT,
        ST_L2_ISSUE,
        ST_L2_WAIT,
        ST_REPLY
    } walk_state_t;

    typedef enum logic [1:0] {
        L1K_FAULT,
        L1K_SECTION,
        L1K_TABLE
    } l1_kind_t;

    typedef struct packed {
        logic [AW-1:0]    paddr;
        logic             cacheable;
        logic             bufferable;
        logic [DOM_W-1:0] domain;
        logic [AP_W-1:0]  ap;
        logic             fault;
        logic             fault_page;
    } walk_result_t;

endpackage

// File: rtl/mmu_ap_pick.sv
// Picks one subpage permission code out of the packed field of a page descriptor.
module mmu_ap_pick #(
    parameter int NSUB  = 4,
    parameter int AP_W  = 2,
    parameter int SEL_W = $clog2(NSUB)
) (
    input  logic [NSUB*AP_W-1:0] ap_field,
    input  logic [SEL_W-1:0]     sel,
    output logic [AP_W-1:0]      ap
);

    logic [AP_W-1:0] slot [NSUB];

    generate
        for (genvar g = 0; g < NSUB; g++) begin : g_slot
            assign slot[g] = ap_field[g*AP_W +: AP_W];
        end
    endgenerate

    assign ap = slot[sel];   // R7

endmodule

// File: rtl/mmu_l1_decode.sv
// Classifies a first-level descriptor and derives the section mapping or
// the second-level lookup address from it.
module mmu_l1_decode
    import mmu_walk_pkg::*;
(
    input  logic [DW-1:0]    desc,
    input  logic [AW-1:0]    vaddr,
    output l1_kind_t         kind,
    output logic [AW-1:0]    sect_paddr,
    output logic [AW-1:0]    l2_addr,
    output logic [DOM_W-1:0] domain,
    output logic             cacheable,
    output logic             bufferable,
    output logic [AP_W-1:0]  ap
);

    always_comb begin
        unique case (desc[1:0])
            2'b10:   kind = L1K_SECTION;   // R2
            2'b01:   kind = L1K_TABLE;     // R4
            default: kind = L1K_FAULT;     // R8
        endcase
    end

    // R2: section base joined with the in-section offset
    assign sect_paddr = {desc[DW-1:SECT_LSB], vaddr[SECT_LSB-1:0]};
    // R4: page table base, then the second-level index, word aligned
    assign l2_addr    = {desc[DW-1:L2_BASE_LSB], vaddr[SECT_LSB-1:SMALL_LSB], 2'b00};
    assign domain     = desc[DOM_LSB +: DOM_W];
    assign cacheable  = desc[3];    // R3
    assign bufferable = desc[2];    // R3
    assign ap         = desc[SECT_AP_LSB +: AP_W];

endmodule

// File: rtl/mmu_l2_decode.sv
// Decodes a second-level page descriptor into the final mapping.
module mmu_l2_decode
    import mmu_walk_pkg::*;
(
    input  logic [DW-1:0]   desc,
    input  logic [AW-1:0]   vaddr,
    output logic            ok,
    output logic [AW-1:0]   paddr,
    output logic            cacheable,
    output logic            bufferable,
    output logic [AP_W-1:0] ap
);

    logic                 is_small;
    logic                 is_large;
    logic                 large_clean;
    logic [SUB_SEL_W-1:0] sub_sel;

    always_comb begin
        is_small = 1'b0;
        is_large = 1'b0;
        unique case (desc[1:0])
            2'b10:   is_small = 1'b1;   // R5
            2'b01:   is_large = 1'b1;   // R6
            default: ;                  // R9: fault types
        endcase
    end

    // R6: large-page descriptors keep bits 15:12 clear
    assign large_clean = (desc[LARGE_LSB-1:SMALL_LSB] == '0);
    assign ok          = is_small | (is_large & large_clean);

    // R7: subpage index comes from different virtual address bits per size
    assign sub_sel = is_large ? vaddr[LARGE_SUB_LSB +: SUB_SEL_W]
                              : vaddr[SMALL_SUB_LSB +: SUB_SEL_W];

    always_comb begin
        if (is_large)
            paddr = {desc[DW-1:LARGE_LSB], vaddr[LARGE_LSB-1:0]};   // R6
        else
            paddr = {desc[DW-1:SMALL_LSB], vaddr[SMALL_LSB-1:0]};   // R5
    end

    assign cacheable  = desc[3];   // R3
    assign bufferable = desc[2];   // R3

    mmu_ap_pick #(
        .NSUB (NSUB),
        .AP_W (AP_W)
    ) u_ap_pick (
        .ap_field (desc[AP_LSB +: NSUB*AP_W]),
        .sel      (sub_sel),
        .ap       (ap)
    );

endmodule

// File: rtl/mmu_table_walker.sv
module mmu_table_walker
    import mmu_walk_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [31:0]   req_vaddr,
    input  logic [31:0]   req_table_base,
    output logic          mem_rd_valid,
    input  logic          mem_rd_ready,
    output logic [31:0]   mem_rd_addr,
    input  logic          mem_rsp_valid,
    input  logic [31:0]   mem_rsp_data,
    output logic          res_valid,
    output logic [31:0]   res_paddr,
    output logic          res_cacheable,
    output logic          res_bufferable,
    output logic [3:0]    res_domain,
    output logic [1:0]    res_ap,
    output logic          res_fault,
    output logic          res_fault_page
);

    walk_state_t      state_q, state_d;
    logic [AW-1:0]    va_q;
    logic [AW-1:0]    rd_addr_q;
    logic [DOM_W-1:0] l1_dom_q;
    walk_result_t     res_q;

    // first-level decode
    l1_kind_t         l1_kind;
    logic [AW-1:0]    l1_sect_paddr;
    logic [AW-1:0]    l1_l2_addr;
    logic [DOM_W-1:0] l1_dom;
    logic             l1_c, l1_b;
    logic [AP_W-1:0]  l1_ap;

    // second-level decode
    logic             l2_ok;
    logic [AW-1:0]    l2_paddr;
    logic             l2_c, l2_b;
    logic [AP_W-1:0]  l2_ap;

    mmu_l1_decode u_l1 (
        .desc       (mem_rsp_data),
        .vaddr      (va_q),
        .kind       (l1_kind),
        .sect_paddr (l1_sect_paddr),
        .l2_addr    (l1_l2_addr),
        .domain     (l1_dom),
        .cacheable  (l1_c),
        .bufferable (l1_b),
        .ap         (l1_ap)
    );

    mmu_l2_decode u_l2 (
        .desc       (mem_rsp_data),
        .vaddr      (va_q),
        .ok         (l2_ok),
        .paddr      (l2_paddr),
        .cacheable  (l2_c),
        .bufferable (l2_b),
        .ap         (l2_ap)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;   // R12
        else        state_q <= state_d;
    end

    // ---------------- transitions ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid)     state_d = ST_L1_ISSUE;
            ST_L1_ISSUE: if (mem_rd_ready)  state_d = ST_L1_WAIT;
            ST_L1_WAIT:  if (mem_rsp_valid) state_d = (l1_kind == L1K_TABLE) ? ST_L2_ISSUE : ST_REPLY;
            ST_L2_ISSUE: if (mem_rd_ready)  state_d = ST_L2_WAIT;
            ST_L2_WAIT:  if (mem_rsp_valid) state_d = ST_REPLY;
            ST_REPLY:                       state_d = ST_IDLE;
            default:                        state_d = ST_IDLE;
        endcase
    end

    // ---------------- walk datapath ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q      <= '0;
            rd_addr_q <= '0;
            l1_dom_q  <= '0;
            res_q     <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q      <= req_vaddr;
                        // R1: table base, first-level index, word aligned
                        rd_addr_q <= {req_table_base[AW-1:TB_LSB], req_vaddr[AW-1:SECT_LSB], 2'b00};
                    end
                end
                ST_L1_WAIT: begin
                    if (mem_rsp_valid) begin
                        unique case (l1_kind)
                            L1K_SECTION: begin   // R2, R3
                                res_q.paddr      <= l1_sect_paddr;
                                res_q.cacheable  <= l1_c;
                                res_q.bufferable <= l1_b;
                                res_q.domain     <= l1_dom;
                                res_q.ap         <= l1_ap;
                                res_q.fault      <= 1'b0;
                                res_q.fault_page <= 1'b0;
                            end
                            L1K_TABLE: begin     // R4
                                rd_addr_q <= l1_l2_addr;
                                l1_dom_q  <= l1_dom;
                            end
                            default: begin       // R8
                                res_q            <= '0;
                                res_q.fault      <= 1'b1;
                            end
                        endcase
                    end
                end
                ST_L2_WAIT: begin
                    if (mem_rsp_valid) begin
                        res_q.domain <= l1_dom_q;
                        if (l2_ok) begin         // R5, R6, R7, R3
                            res_q.paddr      <= l2_paddr;
                            res_q.cacheable  <= l2_c;
                            res_q.bufferable <= l2_b;
                            res_q.ap         <= l2_ap;
                            res_q.fault      <= 1'b0;
                            res_q.fault_page <= 1'b0;
                        end else begin           // R9
                            res_q.paddr      <= '0;
                            res_q.cacheable  <= 1'b0;
                            res_q.bufferable <= 1'b0;
                            res_q.ap         <= '0;
                            res_q.fault      <= 1'b1;
                            res_q.fault_page <= 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        req_ready      = (state_q == ST_IDLE);                                  // R11
        mem_rd_valid   = (state_q == ST_L1_ISSUE) || (state_q == ST_L2_ISSUE);  // R10
        mem_rd_addr    = rd_addr_q;
        res_valid      = (state_q == ST_REPLY);                                 // R11
        res_paddr      = res_q.paddr;
        res_cacheable  = res_q.cacheable;
        res_bufferable = res_q.bufferable;
        res_domain     = res_q.domain;
        res_ap         = res_q.ap;
        res_fault      = res_q.fault;
        res_fault_page = res_q.fault_page;
    end

    // ---------------- assertions ----------------
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr))); // R10

    AST_RD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> (mem_rd_addr[1:0] == 2'b00)); // R1

    AST_RES_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R11

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid || res_valid) |-> !req_ready); // R11

    AST_FAULT_NO_PADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault) |-> (res_paddr == '0 && res_ap == '0)); // R8

    AST_ACCEPT_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> mem_rd_valid); // R1

endmodule

// File: tb/mmu_table_walker_test.sv
`timescale 1ns/1ps
module mmu_table_walker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [31:0] req_table_base = '0;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        res_valid;
    logic [31:0] res_paddr;
    logic        res_cacheable, res_bufferable;
    logic [3:0]  res_domain;
    logic [1:0]  res_ap;
    logic        res_fault, res_fault_page;

    always #2.5 clk = ~clk;   // 200 MHz

    mmu_table_walker uut (.*);

    int n_cmp = 0;
    int n_bad = 0;
    int n_req = 0;
    int n_pulse = 0;
    bit finished = 0;

    // memory model state
    logic [31:0] mem_tbl [logic [31:0]];
    int          stall_cfg = 0;
    int          wait_cnt = 0;
    int          rd_count = 0;
    logic [31:0] rd_log [4];
    bit          fire_pend = 0;
    logic [31:0] fire_addr = '0;
    int          pend_cnt = 0;
    logic [31:0] pend_addr = '0;

    // captured result
    logic [31:0] g_paddr;
    logic        g_c, g_b, g_fault, g_fpage;
    logic [3:0]  g_dom;
    logic [1:0]  g_ap;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] lookup(input logic [31:0] a);
        if (mem_tbl.exists(a)) return mem_tbl[a];
        return 32'h0;
    endfunction

    // memory responder, acts at falling edges
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (pend_cnt > 0) begin
                pend_cnt--;
                if (pend_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = lookup(pend_addr);
                end
            end
            if (fire_pend) begin
                pend_addr = fire_addr;
                pend_cnt  = 1;
                fire_pend = 0;
            end
            if (mem_rd_valid) begin
                mem_rd_ready = (wait_cnt >= stall_cfg);
                wait_cnt++;
            end else begin
                mem_rd_ready = 1'b0;
                wait_cnt = 0;
            end
            if (mem_rd_valid && mem_rd_ready) begin
                fire_pend = 1;
                fire_addr = mem_rd_addr;
                if (rd_count < 4) rd_log[rd_count] = mem_rd_addr;
                rd_count++;
                wait_cnt = 0;
            end
        end
    end

    // result pulse counter
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && res_valid) n_pulse++;
        end
    end

    // one translation: launch, check busy, wait for the result
    task automatic xlate(input logic [31:0] va, input logic [31:0] tb);
        bit got;
        got = 0;
        rd_count = 0;
        @(negedge clk);
        req_valid      = 1'b1;
        req_vaddr      = va;
        req_table_base = tb;
        @(negedge clk);
        req_valid = 1'b0;
        n_req++;
        chk(req_ready == 1'b0, "R11 busy after accept", {31'b0, req_ready}, 32'h0);
        for (int i = 0; i < 60 && !got; i++) begin
            @(negedge clk);
            if (res_valid) begin
                got     = 1;
                g_paddr = res_paddr;
                g_c     = res_cacheable;
                g_b     = res_bufferable;
                g_dom   = res_domain;
                g_ap    = res_ap;
                g_fault = res_fault;
                g_fpage = res_fault_page;
            end
        end
        chk(got, "R11 result returned", {31'b0, got}, 32'h1);
        @(negedge clk);
        chk(res_valid == 1'b0, "R11 single pulse", {31'b0, res_valid}, 32'h0);
    endtask

    function automatic logic [31:0] l1_addr(input logic [31:0] tb, input logic [31:0] va);
        return (tb & 32'hFFFF_C000) | ((va >> 20) << 2);
    endfunction

    task automatic test_reset();
        chk(req_ready == 1'b1, "R12 req_ready", {31'b0, req_ready}, 32'h1);
        chk(mem_rd_valid == 1'b0, "R12 mem_rd_valid", {31'b0, mem_rd_valid}, 32'h0);
        chk(res_valid == 1'b0, "R12 res_valid", {31'b0, res_valid}, 32'h0);
    endtask

    task automatic test_section();
        logic [31:0] tb, va, d;
        tb = 32'h0012_C000;
        va = 32'hABC1_2345;
        d  = (32'h5A7 << 20) | (32'h3 << 10) | (32'h9 << 5) | (32'h1 << 4) | (32'h1 << 3) | 32'h2;
        mem_tbl[l1_addr(tb, va)] = d;
        stall_cfg = 3;   // R10: ready withheld for several cycles
        xlate(va, tb);
        stall_cfg = 0;
        chk(rd_log[0] == l1_addr(tb, va), "R1 first read address", rd_log[0], l1_addr(tb, va));
        chk(rd_count == 1, "R2 one read", rd_count, 1);
        chk(g_paddr == 32'h5A71_2345, "R2 section paddr", g_paddr, 32'h5A71_2345);
        chk(g_dom == 4'h9 && g_ap == 2'h3, "R2 domain/ap", {24'b0, g_dom, 2'b0, g_ap}, 32'h0000_0093);
        chk(g_c == 1'b1 && g_b == 1'b0, "R3 section c/b", {30'b0, g_c, g_b}, 32'h2);
        chk(g_fault == 1'b0, "R2 no fault", {31'b0, g_fault}, 32'h0);
    endtask

    task automatic test_small();
        logic [31:0] tb, d1, d2, l2a, va, exp_pa;
        tb = 32'h0300_0000;
        d1 = 32'h0040_0400 | (32'h5 << 5) | 32'h1;
        d2 = (32'h12345 << 12) | (32'hE4 << 4) | (32'h1 << 2) | 32'h2;  // codes k -> k
        for (int k = 0; k < 4; k++) begin
            va  = 32'h0037_5000 | (k << 10) | 32'h0AB;
            mem_tbl[l1_addr(tb, va)] = d1;
            l2a = (d1 & 32'hFFFF_FC00) | (((va >> 12) & 32'hFF) << 2);
            mem_tbl[l2a] = d2;
            stall_cfg = k;
            xlate(va, tb);
            exp_pa = 32'h1234_5000 | (va & 32'hFFF);
            chk(rd_count == 2 && rd_log[1] == l2a, "R4 second read address", rd_log[1], l2a);
            chk(g_paddr == exp_pa, "R5 small paddr", g_paddr, exp_pa);
            chk(g_ap == 2'(k), "R7 small subpage ap", {30'b0, g_ap}, k);
            chk(g_dom == 4'h5, "R4 domain from first level", {28'b0, g_dom}, 32'h5);
            chk(g_c == 1'b0 && g_b == 1'b1 && !g_fault, "R3 page c/b", {29'b0, g_fault, g_c, g_b}, 32'h1);
        end
        stall_cfg = 0;
    endtask

    task automatic test_large();
        logic [31:0] tb, d1, d2, l2a, va, exp_pa;
        tb = 32'h0500_4000;
        d1 = 32'h0080_0000 | (32'hC << 5) | 32'h1;
        d2 = (32'hBEEF << 16) | (32'h1B << 4) | (32'h1 << 3) | (32'h1 << 2) | 32'h1;  // k -> 3-k
        for (int k = 0; k < 4; k++) begin
            va  = 32'h4410_0000 | (k << 14) | 32'h1234;
            mem_tbl[l1_addr(tb, va)] = d1;
            l2a = (d1 & 32'hFFFF_FC00) | (((va >> 12) & 32'hFF) << 2);
            mem_tbl[l2a] = d2;
            xlate(va, tb);
            exp_pa = 32'hBEEF_0000 | (va & 32'hFFFF);
            chk(g_paddr == exp_pa && !g_fault, "R6 large paddr", g_paddr, exp_pa);
            chk(g_ap == 2'(3 - k), "R7 large subpage ap", {30'b0, g_ap}, 3 - k);
            chk(g_c && g_b, "R3 large c/b", {30'b0, g_c, g_b}, 32'h3);
        end
        // large page with bits 15:12 set
        va  = 32'h4410_0000;
        l2a = (d1 & 32'hFFFF_FC00);
        mem_tbl[l2a] = d2 | 32'h0000_4000;
        xlate(va, tb);
        chk(g_fault && g_fpage, "R6 dirty large page faults", {30'b0, g_fault, g_fpage}, 32'h3);
        chk(g_paddr == 32'h0, "R6 dirty large no paddr", g_paddr, 32'h0);
    endtask

    task automatic test_l1_faults();
        logic [31:0] tb, va;
        tb = 32'h0700_0000;
        for (int t = 0; t < 2; t++) begin
            va = 32'h0AB0_0000 + (t << 20);
            mem_tbl[l1_addr(tb, va)] = (t == 0) ? 32'hFFFF_FFFC : 32'hFFFF_FFFF;
            xlate(va, tb);
            chk(g_fault && !g_fpage, "R8 section fault", {30'b0, g_fault, g_fpage}, 32'h2);
            chk(rd_count == 1, "R8 no second read", rd_count, 1);
            chk(g_paddr == 0 && g_ap == 0 && g_dom == 0 && !g_c && !g_b, "R8 zero fields", g_paddr, 32'h0);
        end
    endtask

    task automatic test_l2_faults();
        logic [31:0] tb, va, d1, l2a;
        tb = 32'h0900_0000;
        d1 = 32'h00C0_0000 | (32'h3 << 5) | 32'h1;
        for (int t = 0; t < 2; t++) begin
            va = 32'h1230_0000 | (t << 12);
            mem_tbl[l1_addr(tb, va)] = d1;
            l2a = (d1 & 32'hFFFF_FC00) | (((va >> 12) & 32'hFF) << 2);
            mem_tbl[l2a] = (t == 0) ? 32'hFFFF_FFFC : 32'hFFFF_FFFF;
            xlate(va, tb);
            chk(g_fault && g_fpage, "R9 page fault", {30'b0, g_fault, g_fpage}, 32'h3);
            chk(rd_count == 2, "R9 two reads", rd_count, 2);
            chk(g_paddr == 0 && g_ap == 0 && !g_c && !g_b, "R9 zero fields", g_paddr, 32'h0);
        end
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_section();
        test_small();
        test_large();
        test_l1_faults();
        test_l2_faults();
        repeat (3) @(negedge clk);
        chk(n_pulse == n_req, "R11 pulse count", n_pulse, n_req);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule